// File: doc/BRIEF.md
# Two-Bank CMOS Index/Data Host Port

This block sits between an ISA-style host I/O bus and a 256-byte CMOS register file. The host reaches the file through two pointer/data pairs of I/O ports. First the host writes a pointer value to the pointer port of a pair. Then it reads or writes the data port of the same pair to access the byte that the pointer selects. One pair is fixed at I/O 0x70/0x71 and serves the lower half of the space. The other pair sits at a base address supplied by configuration logic and serves the upper half.

Each bus cycle is a single-clock strobe. The block decodes it combinationally. A data-port access appears on the register-file side in the same cycle: a write strobe, or a read whose result goes back onto the host data bus. A pointer write is captured at the next clock edge. Cycles with AEN high are not for this block. While the active-low reset is low, no access of any kind reaches the file.

Top module: `rtc_bank_port`

## Requirements
- R1: A write at I/O 0x70 captures the low 7 bits of the data as the lower-bank pointer at the next clock edge. A read at 0x70 returns that pointer with bit 7 reading as 0.
- R2: A read or write at 0x71 accesses CMOS location {0, lower pointer}. The read result comes from the register-file read data in the same cycle.
- R3: A pointer-port write never asserts `mem_we`. A data-port write asserts `mem_we` for exactly that cycle, with `mem_wdata` equal to the host data.
- R4: The upper pair has its pointer port at `reloc_base` with bit 0 forced to 0, and its data port one address above. Its data accesses reach location {1, upper pointer}.
- R5: Any cycle with `io_aen` high is ignored. It asserts no memory strobe, does not drive the bus, and leaves both pointers unchanged.
- R6: While `rst_n` is low, no memory strobe is asserted and the bus is not driven. A clock edge with `rst_n` low clears both pointers to 0.
- R7: When the upper pair overlaps 0x70 or 0x71, the fixed pair wins those addresses.
- R8: The two pointers are independent. Writing one leaves the other unchanged.
- R9: `io_rdata_oe` is high only when a read strobe hits a decoded port while the write strobe is low. `io_rdata` is 0 whenever `io_rdata_oe` is low. A cycle with both strobes high acts as a write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low system reset; locks out access |
| io_addr | input | 16 | Host I/O address |
| io_aen | input | 1 | Address enable; high marks a cycle not for I/O devices |
| io_rd | input | 1 | Host read strobe, active high, one cycle |
| io_wr | input | 1 | Host write strobe, active high, one cycle |
| io_wdata | input | 8 | Host write data |
| io_rdata | output | 8 | Read data toward the host; 0 when not driven |
| io_rdata_oe | output | 1 | Bus drive enable for `io_rdata` |
| reloc_base | input | 16 | Base address of the upper pair (bit 0 ignored) |
| mem_addr | output | 8 | CMOS location of the current data access |
| mem_we | output | 1 | CMOS write strobe |
| mem_re | output | 1 | CMOS read strobe |
| mem_wdata | output | 8 | CMOS write data |
| mem_rdata | input | 8 | CMOS read data, valid in the same cycle as `mem_re` |

## Verification
The bench builds the block with its default parameters: a 16-bit I/O address, a fixed pair at 0x70 and 7-bit pointers. The upper pair's base is an input, so the bench moves it at run time instead of through parameters. The base values used include a distant even base, an odd base, and bases that land on 0x70 and just below it. These bring the bit-0 masking, the fixed-pair priority and near-neighbour decoding within reach under random traffic.

// File: rtl/rtc_port_pkg.sv
// Shared types for the two-bank CMOS host port.
// Assumes exactly two pointer/data pairs: bank 0 fixed, bank 1 relocatable.
package rtc_port_pkg;
    localparam int BANKS  = 2;
    localparam int BANK_W = 1;

    typedef enum logic [1:0] {
        ACC_NONE  = 2'd0,
        ACC_INDEX = 2'd1,
        ACC_DATA  = 2'd2
    } acc_kind_e;

    typedef struct packed {
        acc_kind_e         kind;
        logic [BANK_W-1:0] bank;
    } acc_sel_t;
endpackage

// File: rtl/rtc_port_decode.sv
// Address decoder: maps a host I/O address to (port kind, bank).
// Assumes the relocatable base is even (bit 0 is forced low here) and that
// the lowest-numbered bank wins when two pairs overlap.
module rtc_port_decode
    import rtc_port_pkg::*;
#(
    parameter int              AW         = 16,
    parameter logic [AW-1:0]   FIXED_BASE = 16'h0070
) (
    input  logic          rst_n,
    input  logic [AW-1:0] io_addr,
    input  logic          io_aen,
    input  logic [AW-1:0] reloc_base,
    output acc_sel_t      sel
);
    logic [AW-1:0]    pair_base [BANKS];
    logic [BANKS-1:0] hit_idx;
    logic [BANKS-1:0] hit_dat;

    // Per-bank base selection and address comparison
    for (genvar b = 0; b < BANKS; b++) begin : g_bank
        if (b == 0) begin : g_fixed
            assign pair_base[b] = FIXED_BASE;
        end else begin : g_reloc
            assign pair_base[b] = {reloc_base[AW-1:1], 1'b0};
        end
        assign hit_idx[b] = (io_addr == pair_base[b]);
        assign hit_dat[b] = (io_addr == (pair_base[b] | AW'(1)));
    end

    // Priority pick: scan downward so bank 0 has the last word
    always_comb begin
        sel.kind = ACC_NONE;
        sel.bank = '0;
        if (rst_n && !io_aen) begin
            for (int b = BANKS - 1; b >= 0; b--) begin
                if (hit_idx[b]) begin
                    sel.kind = ACC_INDEX;
                    sel.bank = BANK_W'(b);
                end else if (hit_dat[b]) begin
                    sel.kind = ACC_DATA;
                    sel.bank = BANK_W'(b);
                end
            end
        end
    end
endmodule

// File: rtl/rtc_index_bank.sv
// Pointer registers, one per bank, each IDX_W bits wide.
// Assumes at most one bank is written per cycle; synchronous active-low reset.
module rtc_index_bank
    import rtc_port_pkg::*;
#(
    parameter int IDX_W = 7
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        wr_en,
    input  logic [BANK_W-1:0]           wr_bank,
    input  logic [IDX_W-1:0]            wr_val,
    output logic [BANKS-1:0][IDX_W-1:0] idx_q
);
    for (genvar b = 0; b < BANKS; b++) begin : g_idx
        // Capture the pointer when this bank's pointer port is written
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                idx_q[b] <= '0;
            end else if (wr_en && (wr_bank == BANK_W'(b))) begin
                idx_q[b] <= wr_val;
            end
        end
    end
endmodule

// File: rtl/rtc_port_route.sv
// Routes a decoded host cycle to the CMOS file or to a pointer register and
// builds the host read data. Assumes single-cycle strobes; a cycle with both
// strobes high is treated as a write.
module rtc_port_route
    import rtc_port_pkg::*;
#(
    parameter int DW    = 8,
    parameter int IDX_W = 7,
    parameter int MAW   = BANK_W + IDX_W
) (
    input  acc_sel_t                    sel,
    input  logic                        io_rd,
    input  logic                        io_wr,
    input  logic [DW-1:0]               io_wdata,
    input  logic [BANKS-1:0][IDX_W-1:0] idx_q,
    input  logic [DW-1:0]               mem_rdata,
    output logic [MAW-1:0]              mem_addr,
    output logic                        mem_we,
    output logic                        mem_re,
    output logic [DW-1:0]               mem_wdata,
    output logic                        idx_we,
    output logic [DW-1:0]               io_rdata,
    output logic                        io_rdata_oe
);
    logic [IDX_W-1:0] cur_idx;
    logic             rd_only;

    assign cur_idx   = idx_q[sel.bank];
    assign rd_only   = io_rd && !io_wr;
    assign mem_addr  = {sel.bank, cur_idx};
    assign mem_wdata = io_wdata;

    // Strobe generation toward the file and the pointer registers
    always_comb begin
        mem_we = io_wr   && (sel.kind == ACC_DATA);
        mem_re = rd_only && (sel.kind == ACC_DATA);
        idx_we = io_wr   && (sel.kind == ACC_INDEX);
    end

    // Host read data mux with drive enable
    always_comb begin
        io_rdata_oe = rd_only && (sel.kind != ACC_NONE);
        io_rdata    = '0;
        if (rd_only && sel.kind == ACC_DATA) begin
            io_rdata = mem_rdata;
        end else if (rd_only && sel.kind == ACC_INDEX) begin
            io_rdata = DW'(cur_idx);
        end
    end
endmodule

// File: rtl/rtc_bank_port.sv
// Top: two-bank pointer/data host port onto a 256-byte CMOS register file.
// Bank 0 is fixed at FIXED_BASE/+1, bank 1 follows reloc_base. Access is
// locked out while rst_n is low; cycles with io_aen high are ignored.
module rtc_bank_port
    import rtc_port_pkg::*;
#(
    parameter int            AW         = 16,
    parameter int            DW         = 8,
    parameter int            IDX_W      = 7,
    parameter logic [AW-1:0] FIXED_BASE = 16'h0070,
    localparam int           MAW        = BANK_W + IDX_W
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [AW-1:0]  io_addr,
    input  logic           io_aen,
    input  logic           io_rd,
    input  logic           io_wr,
    input  logic [DW-1:0]  io_wdata,
    output logic [DW-1:0]  io_rdata,
    output logic           io_rdata_oe,
    input  logic [AW-1:0]  reloc_base,
    output logic [MAW-1:0] mem_addr,
    output logic           mem_we,
    output logic           mem_re,
    output logic [DW-1:0]  mem_wdata,
    input  logic [DW-1:0]  mem_rdata
);
    acc_sel_t                    sel;
    logic [BANKS-1:0][IDX_W-1:0] idx_q;
    logic                        idx_we;

    rtc_port_decode #(.AW(AW), .FIXED_BASE(FIXED_BASE)) u_dec (
        .rst_n      (rst_n),
        .io_addr    (io_addr),
        .io_aen     (io_aen),
        .reloc_base (reloc_base),
        .sel        (sel)
    );

    rtc_index_bank #(.IDX_W(IDX_W)) u_idx (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (idx_we),
        .wr_bank (sel.bank),
        .wr_val  (io_wdata[IDX_W-1:0]),
        .idx_q   (idx_q)
    );

    rtc_port_route #(.DW(DW), .IDX_W(IDX_W), .MAW(MAW)) u_route (
        .sel         (sel),
        .io_rd       (io_rd),
        .io_wr       (io_wr),
        .io_wdata    (io_wdata),
        .idx_q       (idx_q),
        .mem_rdata   (mem_rdata),
        .mem_addr    (mem_addr),
        .mem_we      (mem_we),
        .mem_re      (mem_re),
        .mem_wdata   (mem_wdata),
        .idx_we      (idx_we),
        .io_rdata    (io_rdata),
        .io_rdata_oe (io_rdata_oe)
    );
endmodule

// File: rtl/rtc_bank_port_chk.sv
// Property checker for rtc_bank_port, attached by bind below.
// Observes ports only; assumes the fixed pair sits at FIXED_BASE/+1.
module rtc_bank_port_chk #(
    parameter int            AW         = 16,
    parameter int            DW         = 8,
    parameter int            MAW        = 8,
    parameter logic [AW-1:0] FIXED_BASE = 16'h0070
) (
    input logic           clk,
    input logic           rst_n,
    input logic [AW-1:0]  io_addr,
    input logic           io_aen,
    input logic           io_rd,
    input logic           io_wr,
    input logic [DW-1:0]  io_wdata,
    input logic [DW-1:0]  io_rdata,
    input logic           io_rdata_oe,
    input logic [MAW-1:0] mem_addr,
    input logic           mem_we,
    input logic           mem_re,
    input logic [DW-1:0]  mem_wdata
);
    // R6: lockout during reset, sampled at each edge
    always @(posedge clk) begin
        if (!rst_n) begin
            p_lockout_r6: assert (!mem_we && !mem_re && !io_rdata_oe)
                else $error("access while reset low");
        end
    end

    p_aen_ignored_r5: assert property (@(posedge clk) disable iff (!rst_n)
        io_aen |-> (!mem_we && !mem_re && !io_rdata_oe));

    p_oe_needs_read_r9: assert property (@(posedge clk) disable iff (!rst_n)
        io_rdata_oe |-> (io_rd && !io_wr));

    p_idle_bus_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !io_rdata_oe |-> (io_rdata == '0));

    p_ptr_write_no_mem_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (io_wr && !io_aen && io_addr == FIXED_BASE) |-> !mem_we);

    p_fixed_low_half_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_we && io_addr == (FIXED_BASE | AW'(1))) |-> !mem_addr[MAW-1]);

    p_wdata_passes_r3: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> (mem_wdata == io_wdata && io_wr));

    p_strobes_exclusive_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_we && mem_re));
endmodule

bind rtc_bank_port rtc_bank_port_chk #(
    .AW(AW), .DW(DW), .MAW(MAW), .FIXED_BASE(FIXED_BASE)
) u_chk (
    .clk(clk), .rst_n(rst_n), .io_addr(io_addr), .io_aen(io_aen),
    .io_rd(io_rd), .io_wr(io_wr), .io_wdata(io_wdata), .io_rdata(io_rdata),
    .io_rdata_oe(io_rdata_oe), .mem_addr(mem_addr), .mem_we(mem_we),
    .mem_re(mem_re), .mem_wdata(mem_wdata)
);

// File: tb/tb_rtc_bank_port.sv
module tb_rtc_bank_port;
    logic        clk = 1'b0;
    logic        rst_n;
    logic [15:0] io_addr;
    logic        io_aen, io_rd, io_wr;
    logic [7:0]  io_wdata, io_rdata;
    logic        io_rdata_oe;
    logic [15:0] reloc_base;
    logic [7:0]  mem_addr, mem_wdata, mem_rdata;
    logic        mem_we, mem_re;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    logic [7:0] ram    [256];   // register file attached to the DUT
    logic [7:0] shadow [256];   // expected contents
    logic [6:0] midx   [2];     // expected pointers

    rtc_bank_port dut (
        .clk(clk), .rst_n(rst_n), .io_addr(io_addr), .io_aen(io_aen),
        .io_rd(io_rd), .io_wr(io_wr), .io_wdata(io_wdata),
        .io_rdata(io_rdata), .io_rdata_oe(io_rdata_oe),
        .reloc_base(reloc_base), .mem_addr(mem_addr), .mem_we(mem_we),
        .mem_re(mem_re), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
    );

    always #10 clk = ~clk;  // 50 MHz

    assign mem_rdata = ram[mem_addr];
    always @(posedge clk) if (mem_we) ram[mem_addr] <= mem_wdata;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    // kind: 0 none, 1 pointer, 2 data
    function automatic int exp_kind(input logic [15:0] a, input bit aen, input bit rs, output int bank);
        logic [15:0] eb;
        eb   = {reloc_base[15:1], 1'b0};
        bank = 0;
        if (!rs || aen)                   return 0;
        if (a == 16'h0070)                return 1;
        if (a == 16'h0071)                return 2;
        bank = 1;
        if (a == eb)                      return 1;
        if (a == (eb | 16'h1))            return 2;
        bank = 0;
        return 0;
    endfunction

    task automatic cycle(input logic [15:0] a, input bit aen, input bit wr, input bit rd,
                         input logic [7:0] d, input bit rs, input string tag_in);
        int k, b;
        string tag;
        logic [7:0] ea, er;
        bit eoe;
        @(negedge clk);
        io_addr = a; io_aen = aen; io_wr = wr; io_rd = rd; io_wdata = d; rst_n = rs;
        #4;
        k = exp_kind(a, aen, rs, b);
        if (tag_in != "")      tag = tag_in;
        else if (!rs)          tag = "R6";
        else if (aen)          tag = "R5";
        else if (k == 0)       tag = "R9";
        else if (b == 1)       tag = "R4";
        else if (k == 1)       tag = "R1";
        else                   tag = "R2";
        ea  = {b[0], midx[b]};
        eoe = rd && !wr && k != 0;
        er  = !eoe ? 8'h00 : (k == 1 ? {1'b0, midx[b]} : shadow[ea]);
        chk(io_rdata_oe == eoe, tag, io_rdata_oe, eoe);
        chk(io_rdata == er, tag, io_rdata, er);
        chk(mem_we == (wr && k == 2), (k == 1) ? "R3" : tag, mem_we, wr && k == 2);
        chk(mem_re == (rd && !wr && k == 2), tag, mem_re, rd && !wr && k == 2);
        if (k == 2 && (wr || rd)) chk(mem_addr == ea, tag, mem_addr, ea);
        if (k == 2 && wr)         chk(mem_wdata == d, "R3", mem_wdata, d);
        if (!rs) begin
            midx[0] = '0; midx[1] = '0;
        end else if (wr && k == 1) begin
            midx[b] = d[6:0];
        end else if (wr && k == 2) begin
            shadow[ea] = d;
        end
    endtask

    task automatic idle();
        cycle(16'h0000, 1'b0, 1'b0, 1'b0, 8'h00, 1'b1, "");
    endtask

    initial begin
        #3000000;  // 150,000 cycles
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h1234_5678));
        for (int i = 0; i < 256; i++) begin
            ram[i] = 8'($urandom);
            shadow[i] = ram[i];
        end
        midx[0] = '0; midx[1] = '0;
        reloc_base = 16'h0370;
        io_addr = '0; io_aen = 0; io_rd = 0; io_wr = 0; io_wdata = '0; rst_n = 0;
        // reset state: locked out, pointers zero
        cycle(16'h0071, 1'b0, 1'b0, 1'b1, 8'h00, 1'b0, "R6");
        cycle(16'h0070, 1'b0, 1'b1, 1'b0, 8'h55, 1'b0, "R6");
        cycle(16'h0070, 1'b0, 1'b0, 1'b1, 8'h00, 1'b1, "R6");

        // R1/R2: pointer bit 7 dropped, data written and read back
        cycle(16'h0070, 1'b0, 1'b1, 1'b0, 8'hA5, 1'b1, "R1");
        cycle(16'h0070, 1'b0, 1'b0, 1'b1, 8'h00, 1'b1, "R1");
        cycle(16'h0071, 1'b0, 1'b1, 1'b0, 8'h3C, 1'b1, "R2");
        cycle(16'h0071, 1'b0, 1'b0, 1'b1, 8'h00, 1'b1, "R2");
        // R4/R8: upper bank, lower pointer unaffected
        cycle(16'h0370, 1'b0, 1'b1, 1'b0, 8'h25, 1'b1, "R8");
        cycle(16'h0371, 1'b0, 1'b1, 1'b0, 8'hC3, 1'b1, "R4");
        cycle(16'h0070, 1'b0, 1'b0, 1'b1, 8'h00, 1'b1, "R8");
        cycle(16'h0370, 1'b0, 1'b0, 1'b1, 8'h00, 1'b1, "R8");
        cycle(16'h0371, 1'b0, 1'b0, 1'b1, 8'h00, 1'b1, "R4");
        // R5: AEN cycles ignored, pointer kept
        cycle(16'h0070, 1'b1, 1'b1, 1'b0, 8'h11, 1'b1, "R5");
        cycle(16'h0071, 1'b1, 1'b1, 1'b0, 8'h22, 1'b1, "R5");
        cycle(16'h0070, 1'b0, 1'b0, 1'b1, 8'h00, 1'b1, "R5");
        // R9: both strobes act as write; no drive
        cycle(16'h0071, 1'b0, 1'b1, 1'b1, 8'h77, 1'b1, "R9");
        cycle(16'h0071, 1'b0, 1'b0, 1'b1, 8'h00, 1'b1, "R9");
        // R4: odd base masked to even
        reloc_base = 16'h0241;
        cycle(16'h0240, 1'b0, 1'b1, 1'b0, 8'h7F, 1'b1, "R4");
        cycle(16'h0241, 1'b0, 1'b0, 1'b1, 8'h00, 1'b1, "R4");
        // R7: overlap, fixed pair wins
        reloc_base = 16'h0070;
        cycle(16'h0070, 1'b0, 1'b1, 1'b0, 8'h12, 1'b1, "R7");
        cycle(16'h0071, 1'b0, 1'b1, 1'b0, 8'h9E, 1'b1, "R7");
        cycle(16'h0071, 1'b0, 1'b0, 1'b1, 8'h00, 1'b1, "R7");
        reloc_base = 16'h006E;
        cycle(16'h006F, 1'b0, 1'b0, 1'b1, 8'h00, 1'b1, "R4");
        // R6: mid-run reset clears pointers
        cycle(16'h0000, 1'b0, 1'b0, 1'b0, 8'h00, 1'b0, "R6");
        cycle(16'h0070, 1'b0, 1'b0, 1'b1, 8'h00, 1'b1, "R6");
        cycle(16'h006E, 1'b0, 1'b0, 1'b1, 8'h00, 1'b1, "R6");

        for (int i = 0; i < 4000; i++) begin
            logic [15:0] a, eb;
            int sel;
            if ($urandom_range(0, 99) == 0) begin
                case ($urandom_range(0, 3))
                    0: reloc_base = 16'h0370;
                    1: reloc_base = 16'h0070;
                    2: reloc_base = 16'h0241;
                    default: reloc_base = 16'h006E;
                endcase
            end
            eb  = {reloc_base[15:1], 1'b0};
            sel = $urandom_range(0, 9);
            case (sel)
                0, 1: a = 16'h0070;
                2, 3: a = 16'h0071;
                4, 5: a = eb;
                6, 7: a = eb | 16'h1;
                default: a = 16'($urandom);
            endcase
            cycle(a, $urandom_range(0, 7) == 0, $urandom_range(0, 1) == 1,
                  $urandom_range(0, 1) == 1, 8'($urandom),
                  $urandom_range(0, 59) != 0, "");
            if ($urandom_range(0, 3) == 0) idle();
        end
        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule